// File: doc/BRIEF.md
# RV32I Stimulus Word Generator

This block is a hardware source of pseudo-random 32-bit RV32I instruction words for processor stimulus. A seeded linear feedback shift register supplies the randomness. Each word is built in one of three ways. It can be a plain random word. It can be a random word given a legal major opcode, and sometimes one structured field change as well. It can also be one step of a short multi-word template. The choice is made with percentage weights set by parameters.

Words leave on a valid/ready stream. A word that is offered stays on the port until it is accepted. The generator draws no random bits while it waits, so the stream of words depends only on the seed and not on how the consumer applies back-pressure. A one-cycle seed load pulse restarts the generator from a new seed. It drops any word still on offer and abandons any template in progress. A seed of zero is replaced by the default seed.

Top module: `insn_stream_gen`

## Requirements
- R1: While rst_n is low, insn_valid_o is low. After rst_n is released, the first word is offered within 64 clock cycles.
- R2: Once insn_valid_o is high, it stays high, and insn_o stays unchanged, until a cycle in which insn_ready_i is high or seed_load_i is high.
- R3: For a given seed, the sequence of accepted words is the same whatever the pattern of insn_ready_i.
- R4: A seed_load_i pulse forces insn_valid_o low in the following cycle. The words that follow depend only on seed_i: loading the same seed twice gives the same words, and two different seeds give different words.
- R5: The words produced after reset, the words produced after loading DEFAULT_SEED, and the words produced after loading 0 are all identical.
- R6: With the template weight at 0 and the injection weight at 100, bits [6:0] of every word hold one of these opcodes: 0110111, 0010111, 1101111, 1100111, 1100011, 0000011, 0100011, 0010011, 0110011, 0001111, 1110011.
- R7: With the default weights (template 1%, injection 98%, mutation 20%), at least 93% of 2000 consecutive words carry an opcode from the R6 list.
- R8: With the template and injection weights both at 0, words are raw random values. Opcodes outside the R6 list therefore appear.
- R9: With the injection and mutation weights at 100, every word satisfies at least one of the following:
  - rd[11:7] is 0.
  - rd equals rs1[19:15].
  - rd equals rs2[24:20].
  - rs1 equals rs2.
  - Bits [31:20] hold one of the CSR addresses 0x300, 0x301, 0x304, 0x305, 0x340, 0x341, 0x342, 0x343.
  - The immediate field is one of MIN, -1, 0, 1 or MAX for its width. The field depends on the opcode:
    - For opcodes 0100011 and 1100011, it is the 12-bit field {[31:25],[11:7]}.
    - For opcodes 0110111, 0010111 and 1101111, it is the 20-bit field [31:12].
    - For all other opcodes, it is the 12-bit field [31:20].
- R10: The constant-load template is a LUI (0110111) with a non-zero rd. It is followed by an ADDI (0010011, funct3 000) that uses that same register as both rd and rs1.
- R11: The compute-chain template is CHAIN_LEN words with opcode 0110011, each with a non-zero rd. In each word after the first, rs1 equals the rd of the word before it. Each word's funct3/funct7 pair is one of ADD, SUB, SLL, XOR, SRL, SRA, OR, AND.
- R12: The CSR template has two words. The first has opcode 1110011, a funct3 from {1,2,3,5,6,7}, a CSR address from the R9 list and a non-zero rd. The second is an ADDI with immediate 0, a non-zero rd, and rs1 equal to the first word's rd.
- R13: A template, once started, emits all of its words consecutively. With the template weight at 100, every word belongs to a template, and all three template kinds occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load_i | input | 1 | One-cycle pulse that reloads the generator from seed_i |
| seed_i | input | 32 | Seed value; 0 selects DEFAULT_SEED |
| insn_valid_o | output | 1 | A word is on offer |
| insn_ready_i | input | 1 | Consumer accepts the offered word |
| insn_o | output | 32 | Offered instruction word |

## Verification
The bench stalls the consumer in a fixed pattern and compares the result against an unstalled run. A design that kept drawing random bits while waiting would produce a different stream. Seed zero and a mid-stream seed load are both exercised. A generator that kept a stale template, or kept a half-offered word, would show a changed first word or a valid that stays high. With the template weight forced to 100, the stream is parsed word by word. A broken register link in the chain, a CSR move that reads the wrong register, or an interleaved template all fail the parse. Field mutations are checked against the full list of allowed outcomes, including the split store/branch immediate. A design that wrote the special value into the wrong bits would therefore be caught.

// File: rtl/insn_gen_pkg.sv
package insn_gen_pkg;

  localparam int NUM_OPC = 11;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_FENCE  = 7'b0001111;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  typedef enum logic [2:0] {
    ST_ROLL, ST_SEQ, ST_RAW, ST_INJ, ST_MUT, ST_SHOW
  } gen_state_e;

  typedef enum logic [1:0] {
    SQ_CONST = 2'd0, SQ_CHAIN = 2'd1, SQ_CSR = 2'd2, SQ_NONE = 2'd3
  } seq_kind_e;

  function automatic logic [6:0] opcode_at(input logic [3:0] idx);
    case (idx)
      4'd0:    return OPC_LUI;
      4'd1:    return OPC_AUIPC;
      4'd2:    return OPC_JAL;
      4'd3:    return OPC_JALR;
      4'd4:    return OPC_BRANCH;
      4'd5:    return OPC_LOAD;
      4'd6:    return OPC_STORE;
      4'd7:    return OPC_OPIMM;
      4'd8:    return OPC_OP;
      4'd9:    return OPC_FENCE;
      default: return OPC_SYSTEM;
    endcase
  endfunction

  function automatic logic opcode_legal(input logic [6:0] opc);
    for (int k = 0; k < NUM_OPC; k++)
      if (opcode_at(4'(k)) == opc) return 1'b1;
    return 1'b0;
  endfunction

  // Machine-level CSR addresses the mutation and CSR template draw from
  function automatic logic [11:0] csr_at(input logic [2:0] idx);
    case (idx)
      3'd0:    return 12'h300;
      3'd1:    return 12'h301;
      3'd2:    return 12'h304;
      3'd3:    return 12'h305;
      3'd4:    return 12'h340;
      3'd5:    return 12'h341;
      3'd6:    return 12'h342;
      default: return 12'h343;
    endcase
  endfunction

  function automatic logic [4:0] nonzero_reg(input logic [4:0] r);
    return (r == 5'd0) ? 5'd1 : r;
  endfunction

endpackage

// File: rtl/insn_gen_lfsr.sv
module insn_gen_lfsr #(
  parameter int           W          = 32,
  parameter int           STEPS      = 32,
  parameter logic [W-1:0] TAPS       = W'(32'h80200003),
  parameter logic [W-1:0] RESET_SEED = W'(32'h1D872B41)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);

  logic [W-1:0] state_q;

  // Several Galois shifts per draw so consecutive draws share few bits
  function automatic logic [W-1:0] leap(input logic [W-1:0] s);
    logic [W-1:0] v;
    v = s;
    for (int k = 0; k < STEPS; k++)
      v = v[0] ? ((v >> 1) ^ TAPS) : (v >> 1);
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= RESET_SEED;
    else if (load_i) state_q <= (seed_i == '0) ? RESET_SEED : seed_i;
    else if (adv_i)  state_q <= leap(state_q);
  end

  assign state_o = state_q;

endmodule

// File: rtl/insn_gen_mutate.sv
module insn_gen_mutate
  import insn_gen_pkg::*;
(
  input  logic [31:0] word_i,
  input  logic [2:0]  rule_i,
  input  logic [2:0]  pick_i,
  output logic [31:0] word_o,
  output logic        reject_o
);

  logic       split_imm;
  logic       upper_imm;
  logic [19:0] special;

  // Special immediates for a 12-bit or 20-bit field
  function automatic logic [19:0] edge_val(input logic [2:0] sel, input logic wide);
    logic [19:0] msb;
    msb = wide ? 20'h80000 : 20'h00800;
    case (sel)
      3'd0:    return msb;
      3'd1:    return (msb << 1) - 20'd1;
      3'd2:    return 20'd0;
      3'd3:    return 20'd1;
      default: return msb - 20'd1;
    endcase
  endfunction

  always_comb begin
    split_imm = (word_i[6:0] == OPC_STORE) || (word_i[6:0] == OPC_BRANCH);
    upper_imm = (word_i[6:0] == OPC_LUI) || (word_i[6:0] == OPC_AUIPC) ||
                (word_i[6:0] == OPC_JAL);
    special   = edge_val(pick_i, upper_imm);
  end

  always_comb begin
    word_o   = word_i;
    reject_o = 1'b0;
    case (rule_i)
      3'd0: begin
        if (pick_i > 3'd4) reject_o = 1'b1;
        else if (upper_imm) word_o[31:12] = special;
        else if (split_imm) begin
          word_o[31:25] = special[11:5];
          word_o[11:7]  = special[4:0];
        end else word_o[31:20] = special[11:0];
      end
      3'd1: word_o[11:7]  = 5'd0;
      3'd2: word_o[11:7]  = word_i[19:15];
      3'd3: word_o[11:7]  = word_i[24:20];
      3'd4: word_o[19:15] = word_i[24:20];
      3'd5: word_o[31:20] = csr_at(pick_i);
      default: reject_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/insn_gen_seq.sv
module insn_gen_seq
  import insn_gen_pkg::*;
#(
  parameter int CHAIN_LEN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear_i,
  input  logic        start_i,
  input  seq_kind_e   kind_i,
  input  logic [4:0]  rd_i,
  input  logic        emit_i,
  input  logic [31:0] rnd_i,
  output logic        active_o,
  output logic [31:0] word_o
);

  localparam int IW = $clog2(CHAIN_LEN + 1);

  seq_kind_e   kind_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] last_idx;
  logic [4:0]  base_rd_q;
  logic [4:0]  link_rd_q;
  logic [11:0] lo_q;
  logic [19:0] upper;
  logic [6:0]  f7;
  logic [2:0]  f3;
  logic [2:0]  csr_f3;

  always_comb begin
    case (rnd_i[27:25])
      3'd0: begin f7 = 7'h00; f3 = 3'b000; end
      3'd1: begin f7 = 7'h20; f3 = 3'b000; end
      3'd2: begin f7 = 7'h00; f3 = 3'b001; end
      3'd3: begin f7 = 7'h00; f3 = 3'b100; end
      3'd4: begin f7 = 7'h00; f3 = 3'b101; end
      3'd5: begin f7 = 7'h20; f3 = 3'b101; end
      3'd6: begin f7 = 7'h00; f3 = 3'b110; end
      default: begin f7 = 7'h00; f3 = 3'b111; end
    endcase
    csr_f3 = rnd_i[14:12];
    if (csr_f3[1:0] == 2'b00) csr_f3[0] = 1'b1;
    // LUI part rounds up when the low half will sign-extend negative
    upper    = rnd_i[31:12] + {19'd0, rnd_i[11]};
    last_idx = (kind_q == SQ_CHAIN) ? IW'(CHAIN_LEN - 1) : IW'(1);
  end

  always_comb begin
    word_o = '0;
    case (kind_q)
      SQ_CONST:
        word_o = (idx_q == '0) ? {upper, base_rd_q, OPC_LUI}
                               : {lo_q, base_rd_q, 3'b000, base_rd_q, OPC_OPIMM};
      SQ_CHAIN:
        word_o = {f7, rnd_i[24:20], (idx_q == '0) ? rnd_i[19:15] : link_rd_q,
                  f3, nonzero_reg(rnd_i[11:7]), OPC_OP};
      SQ_CSR:
        word_o = (idx_q == '0)
               ? {csr_at(rnd_i[22:20]), rnd_i[19:15], csr_f3, base_rd_q, OPC_SYSTEM}
               : {12'h000, base_rd_q, 3'b000, nonzero_reg(rnd_i[11:7]), OPC_OPIMM};
      default: word_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q    <= SQ_NONE;
      idx_q     <= '0;
      base_rd_q <= 5'd1;
      link_rd_q <= 5'd1;
      lo_q      <= '0;
    end else if (clear_i) begin
      kind_q <= SQ_NONE;
      idx_q  <= '0;
    end else if (start_i) begin
      kind_q    <= kind_i;
      idx_q     <= '0;
      base_rd_q <= nonzero_reg(rd_i);
    end else if (emit_i && kind_q != SQ_NONE) begin
      link_rd_q <= word_o[11:7];
      lo_q      <= rnd_i[11:0];
      if (idx_q == last_idx) begin
        kind_q <= SQ_NONE;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + IW'(1);
      end
    end
  end

  assign active_o = (kind_q != SQ_NONE);

endmodule

// File: rtl/insn_stream_gen.sv
module insn_stream_gen
  import insn_gen_pkg::*;
#(
  parameter int          SEQ_PCT      = 1,
  parameter int          INJ_PCT      = 98,
  parameter int          MUT_PCT      = 20,
  parameter int          CHAIN_LEN    = 4,
  parameter logic [31:0] DEFAULT_SEED = 32'h1D872B41
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed_load_i,
  input  logic [31:0] seed_i,
  output logic        insn_valid_o,
  input  logic        insn_ready_i,
  output logic [31:0] insn_o
);

  localparam logic [6:0] SEQ_TH = 7'(SEQ_PCT);
  localparam logic [6:0] INJ_TH = 7'(INJ_PCT);
  localparam logic [6:0] MUT_TH = 7'(MUT_PCT);
  localparam logic [6:0] PCT_LIMIT = 7'd100;

  gen_state_e  state_q, state_d;
  logic [31:0] word_q, word_d;
  logic [31:0] rnd;
  logic [6:0]  pct;
  logic        pct_ok;
  logic        seq_start, seq_emit, seq_active;
  logic [31:0] seq_word;
  logic [31:0] mut_word;
  logic        mut_reject;

  // Randomness advances only while a word is being built
  insn_gen_lfsr #(
    .W(32), .STEPS(32), .TAPS(32'h80200003), .RESET_SEED(DEFAULT_SEED)
  ) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load_i(seed_load_i), .seed_i(seed_i),
    .adv_i(state_q != ST_SHOW), .state_o(rnd)
  );

  insn_gen_seq #(.CHAIN_LEN(CHAIN_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .clear_i(seed_load_i), .start_i(seq_start),
    .kind_i(seq_kind_e'(rnd[8:7])), .rd_i(rnd[13:9]), .emit_i(seq_emit),
    .rnd_i(rnd), .active_o(seq_active), .word_o(seq_word)
  );

  insn_gen_mutate u_mut (
    .word_i(word_q), .rule_i(rnd[9:7]), .pick_i(rnd[13:11]),
    .word_o(mut_word), .reject_o(mut_reject)
  );

  assign pct    = rnd[6:0];
  assign pct_ok = pct < PCT_LIMIT;   // out-of-range draws are retried

  always_comb begin
    state_d   = state_q;
    word_d    = word_q;
    seq_start = 1'b0;
    seq_emit  = 1'b0;
    case (state_q)
      ST_ROLL: if (pct_ok) begin
        if (pct < SEQ_TH) begin
          if (rnd[8:7] != 2'd3) begin
            seq_start = 1'b1;
            state_d   = ST_SEQ;
          end
        end else state_d = ST_RAW;
      end
      ST_SEQ: begin
        seq_emit = 1'b1;
        word_d   = seq_word;
        state_d  = ST_SHOW;
      end
      ST_RAW: begin
        word_d  = rnd;
        state_d = ST_INJ;
      end
      ST_INJ: if (pct_ok) begin
        if (pct < INJ_TH) begin
          if (rnd[10:7] < 4'(NUM_OPC)) begin
            word_d  = {word_q[31:7], opcode_at(rnd[10:7])};
            state_d = ST_MUT;
          end
        end else state_d = ST_SHOW;
      end
      ST_MUT: if (pct_ok) begin
        if (pct < MUT_TH) begin
          if (!mut_reject) begin
            word_d  = mut_word;
            state_d = ST_SHOW;
          end
        end else state_d = ST_SHOW;
      end
      ST_SHOW: if (insn_ready_i) state_d = seq_active ? ST_SEQ : ST_ROLL;
      default: state_d = ST_ROLL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ROLL;
      word_q  <= '0;
    end else if (seed_load_i) begin
      state_q <= ST_ROLL;
    end else begin
      state_q <= state_d;
      word_q  <= word_d;
    end
  end

  assign insn_valid_o = (state_q == ST_SHOW);
  assign insn_o       = word_q;

endmodule

// File: rtl/insn_stream_gen_chk.sv
module insn_stream_gen_chk
  import insn_gen_pkg::*;
#(
  parameter int SEQ_PCT = 1,
  parameter int INJ_PCT = 98
) (
  input logic        clk,
  input logic        rst_n,
  input logic        seed_load_i,
  input logic        insn_ready_i,
  input logic        insn_valid_o,
  input logic [31:0] insn_o
);

  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !insn_valid_o);

  assert_valid_until_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid_o && !insn_ready_i && !seed_load_i |=> insn_valid_o);

  assert_word_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid_o && !insn_ready_i && !seed_load_i |=> $stable(insn_o));

  assert_seed_drops_offer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load_i |=> !insn_valid_o);

  generate
    if (SEQ_PCT == 0 && INJ_PCT >= 100) begin : g_legal
      assert_opcode_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid_o |-> opcode_legal(insn_o[6:0]));
    end
  endgenerate

endmodule

bind insn_stream_gen insn_stream_gen_chk #(.SEQ_PCT(SEQ_PCT), .INJ_PCT(INJ_PCT)) u_chk (
  .clk(clk), .rst_n(rst_n), .seed_load_i(seed_load_i), .insn_ready_i(insn_ready_i),
  .insn_valid_o(insn_valid_o), .insn_o(insn_o)
);

// File: tb/sim_insn_stream_gen.sv
module sim_insn_stream_gen;

  localparam logic [31:0] DSEED = 32'h1D872B41;
  localparam int CHAIN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load0 = 1'b0;
  logic [31:0] seed0 = '0;
  logic        rdy [5];
  logic        vld [5];
  logic [31:0] wd  [5];
  logic [31:0] cap  [64];
  logic [31:0] refw [64];
  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  insn_stream_gen #(.DEFAULT_SEED(DSEED), .CHAIN_LEN(CHAIN)) u0 (
    .clk(clk), .rst_n(rst_n), .seed_load_i(load0), .seed_i(seed0),
    .insn_valid_o(vld[0]), .insn_ready_i(rdy[0]), .insn_o(wd[0]));
  insn_stream_gen #(.SEQ_PCT(100), .DEFAULT_SEED(DSEED), .CHAIN_LEN(CHAIN)) u1 (
    .clk(clk), .rst_n(rst_n), .seed_load_i(1'b0), .seed_i(32'd0),
    .insn_valid_o(vld[1]), .insn_ready_i(rdy[1]), .insn_o(wd[1]));
  insn_stream_gen #(.SEQ_PCT(0), .INJ_PCT(100), .MUT_PCT(0), .DEFAULT_SEED(DSEED)) u2 (
    .clk(clk), .rst_n(rst_n), .seed_load_i(1'b0), .seed_i(32'd0),
    .insn_valid_o(vld[2]), .insn_ready_i(rdy[2]), .insn_o(wd[2]));
  insn_stream_gen #(.SEQ_PCT(0), .INJ_PCT(100), .MUT_PCT(100), .DEFAULT_SEED(DSEED)) u3 (
    .clk(clk), .rst_n(rst_n), .seed_load_i(1'b0), .seed_i(32'd0),
    .insn_valid_o(vld[3]), .insn_ready_i(rdy[3]), .insn_o(wd[3]));
  insn_stream_gen #(.SEQ_PCT(0), .INJ_PCT(0), .DEFAULT_SEED(DSEED)) u4 (
    .clk(clk), .rst_n(rst_n), .seed_load_i(1'b0), .seed_i(32'd0),
    .insn_valid_o(vld[4]), .insn_ready_i(rdy[4]), .insn_o(wd[4]));

  function automatic bit legal_op(input logic [6:0] o);
    return o inside {7'b0110111, 7'b0010111, 7'b1101111, 7'b1100111, 7'b1100011,
                     7'b0000011, 7'b0100011, 7'b0010011, 7'b0110011, 7'b0001111,
                     7'b1110011};
  endfunction

  function automatic bit csr_known(input logic [11:0] a);
    return a inside {12'h300, 12'h301, 12'h304, 12'h305, 12'h340, 12'h341, 12'h342, 12'h343};
  endfunction

  function automatic bit mutated_ok(input logic [31:0] w);
    logic [19:0] f;
    logic [19:0] m;
    if (w[11:7] == 5'd0 || w[11:7] == w[19:15] || w[11:7] == w[24:20] ||
        w[19:15] == w[24:20] || csr_known(w[31:20])) return 1'b1;
    if (w[6:0] inside {7'b0110111, 7'b0010111, 7'b1101111}) begin
      f = w[31:12]; m = 20'h80000;
    end else if (w[6:0] inside {7'b0100011, 7'b1100011}) begin
      f = {8'd0, w[31:25], w[11:7]}; m = 20'h00800;
    end else begin
      f = {8'd0, w[31:20]}; m = 20'h00800;
    end
    return f == m || f == (m << 1) - 20'd1 || f == 20'd0 || f == 20'd1 || f == m - 20'd1;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Gather n accepted words from instance sel; optional stall pattern on ready
  task automatic collect(input int sel, input int n, input bit stall);
    int got = 0;
    int cyc = 0;
    while (got < n) begin
      @(negedge clk);
      rdy[sel] = stall ? (cyc % 3 != 0) : 1'b1;
      cyc++;
      if (vld[sel] && rdy[sel]) begin
        cap[got] = wd[sel];
        got++;
      end
    end
    @(negedge clk);
    rdy[sel] = 1'b0;
  endtask

  task automatic load_seed(input logic [31:0] s);
    @(negedge clk);
    seed0 = s;
    load0 = 1'b1;
    @(negedge clk);
    load0 = 1'b0;
    check(vld[0] == 1'b0, "R4 seed load drops offer", 32'(vld[0]), 32'd0);
  endtask

  task automatic save_ref(input int n);
    for (int i = 0; i < n; i++) refw[i] = cap[i];
  endtask

  task automatic compare_ref(input int n, input string req);
    int bad = -1;
    for (int i = 0; i < n; i++) if (bad < 0 && cap[i] !== refw[i]) bad = i;
    if (bad < 0) check(1'b1, req, 32'd0, 32'd0);
    else check(1'b0, req, cap[bad], refw[bad]);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 5; i++) rdy[i] = 1'b0;
    rst_n = 1'b0;
    repeat (4) begin
      @(negedge clk);
      for (int i = 0; i < 5; i++)
        check(vld[i] == 1'b0, "R1 valid low in reset", 32'(vld[i]), 32'd0);
    end
    rst_n = 1'b1;
  endtask

  task automatic t_first_and_hold;
    int waited = 0;
    logic [31:0] held;
    while (!vld[0] && waited < 64) begin
      @(negedge clk);
      waited++;
    end
    check(vld[0] == 1'b1, "R1 first word within 64 cycles", 32'(waited), 32'd64);
    held = wd[0];
    repeat (6) begin
      @(negedge clk);
      check(vld[0] == 1'b1 && wd[0] == held, "R2 offer held under stall", wd[0], held);
    end
  endtask

  task automatic t_default_seed;
    collect(0, 16, 1'b0);
    save_ref(16);
    load_seed(DSEED);
    collect(0, 16, 1'b0);
    compare_ref(16, "R5 default seed matches reset stream");
    load_seed(32'd0);
    collect(0, 16, 1'b0);
    compare_ref(16, "R5 zero seed matches reset stream");
  endtask

  task automatic t_seed_and_stall;
    int same = 1;
    load_seed(32'hC0FFEE11);
    collect(0, 32, 1'b0);
    save_ref(32);
    load_seed(32'hC0FFEE11);
    collect(0, 32, 1'b0);
    compare_ref(32, "R4 same seed repeats stream");
    load_seed(32'hC0FFEE11);
    collect(0, 32, 1'b1);
    compare_ref(32, "R3 stalls do not alter stream");
    load_seed(32'h5A5A0F0F);
    collect(0, 32, 1'b0);
    for (int i = 0; i < 32; i++) if (cap[i] !== refw[i]) same = 0;
    check(same == 0, "R4 different seed gives different stream", cap[0], refw[0]);
  endtask

  task automatic t_mix;
    int legal = 0;
    int got = 0;
    load_seed(32'h2468ACE1);
    while (got < 2000) begin
      @(negedge clk);
      rdy[0] = 1'b1;
      if (vld[0]) begin
        if (legal_op(wd[0][6:0])) legal++;
        got++;
      end
    end
    @(negedge clk);
    rdy[0] = 1'b0;
    check(legal >= 1860, "R7 default mix mostly legal opcodes", 32'(legal), 32'd1860);
  endtask

  task automatic t_inject;
    collect(2, 64, 1'b0);
    for (int i = 0; i < 64; i++)
      check(legal_op(cap[i][6:0]), "R6 injected opcode legal", 32'(cap[i][6:0]), 32'd0);
  endtask

  task automatic t_mutate;
    collect(3, 64, 1'b0);
    for (int i = 0; i < 64; i++) begin
      check(legal_op(cap[i][6:0]), "R6 mutated word keeps legal opcode", cap[i], 32'd0);
      check(mutated_ok(cap[i]), "R9 mutation rule visible", cap[i], 32'd0);
    end
  endtask

  task automatic t_raw;
    int illegal = 0;
    collect(4, 64, 1'b1);
    for (int i = 0; i < 64; i++) if (!legal_op(cap[i][6:0])) illegal++;
    check(illegal > 0, "R8 raw words include illegal opcodes", 32'(illegal), 32'd1);
  endtask

  task automatic t_templates;
    int i = 0;
    bit seen_c = 0, seen_k = 0, seen_s = 0;
    collect(1, 64, 1'b1);
    while (i < 64) begin
      if (cap[i][6:0] == 7'b0110111) begin
        if (i + 1 >= 64) break;
        seen_c = 1;
        check(cap[i][11:7] != 5'd0, "R10 LUI rd nonzero", cap[i], 32'd0);
        check(cap[i+1][6:0] == 7'b0010011 && cap[i+1][14:12] == 3'b000 &&
              cap[i+1][11:7] == cap[i][11:7] && cap[i+1][19:15] == cap[i][11:7],
              "R10 ADDI follows LUI on same register", cap[i+1], cap[i]);
        i += 2;
      end else if (cap[i][6:0] == 7'b0110011) begin
        if (i + CHAIN > 64) break;
        seen_k = 1;
        for (int k = 0; k < CHAIN; k++) begin
          check(cap[i+k][6:0] == 7'b0110011 && cap[i+k][11:7] != 5'd0 &&
                {cap[i+k][31:25], cap[i+k][14:12]} inside
                  {10'h000, 10'h100, 10'h001, 10'h004, 10'h005, 10'h105, 10'h006, 10'h007},
                "R11 chain word form", cap[i+k], 32'd0);
          if (k > 0)
            check(cap[i+k][19:15] == cap[i+k-1][11:7], "R11 chain links rd to rs1",
                  32'(cap[i+k][19:15]), 32'(cap[i+k-1][11:7]));
        end
        i += CHAIN;
      end else if (cap[i][6:0] == 7'b1110011) begin
        if (i + 1 >= 64) break;
        seen_s = 1;
        check(cap[i][14:12] inside {3'd1, 3'd2, 3'd3, 3'd5, 3'd6, 3'd7} &&
              csr_known(cap[i][31:20]) && cap[i][11:7] != 5'd0,
              "R12 CSR access word form", cap[i], 32'd0);
        check(cap[i+1][6:0] == 7'b0010011 && cap[i+1][31:20] == 12'd0 &&
              cap[i+1][14:12] == 3'b000 && cap[i+1][11:7] != 5'd0 &&
              cap[i+1][19:15] == cap[i][11:7], "R12 move reads CSR destination",
              cap[i+1], cap[i]);
        i += 2;
      end else begin
        check(1'b0, "R13 word outside any template", cap[i], 32'd0);
        i++;
      end
    end
    check(seen_c && seen_k && seen_s, "R13 all template kinds occur",
          {29'd0, seen_c, seen_k, seen_s}, 32'd7);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_first_and_hold();
    t_default_seed();
    t_seed_and_stall();
    t_mix();
    t_inject();
    t_mutate();
    t_raw();
    t_templates();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule